// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Configuration Register Slave

This block lets an external host read and write a small bank of 8-bit configuration registers over a two-wire serial bus (SMBus / I2C style). Both bus lines are brought through two-flop synchronizers and oversampled by a much faster system clock. The block detects START and STOP framing, tracks when the bus has gone idle through two timeout rules, and answers on a 7-bit slave address. That address is a fixed base value plus the value on four strap inputs, so sixteen copies can share one bus.

A host writes by sending the address byte with the direction bit clear, then a register-index byte, then any number of data bytes. To read, it writes the index, issues a repeated START and sends the address byte with the direction bit set. The slave then shifts register contents out MSB first until the host answers a byte with NACK. The index advances after every data byte. The block drives the data line only as an open-drain pull-down enable. A mode-enable input switches the whole bus interface on or off, and the register contents stay visible in parallel to the rest of the chip.

Top module: `cfg_bus_slave`

## Requirements
- R1: The slave answers the 7-bit address BASE_ADDR (default 0x58) plus the 4-bit strap value. With strap 0 the write address byte is 0xB0, and with strap 15 it is 0xCE. On a match the slave pulls the data line low during the ninth clock of the address byte.
- R2: After an address byte that does not match, the slave gives no ACK and changes no register. It keeps the data line released until the next START.
- R3: A write is: the address byte with bit 0 = 0, then an index byte, then data bytes. The slave ACKs each byte. Only the low log2(NREG) bits of the index byte are used (default: bits 2:0). The index advances by one after each data byte and wraps from NREG-1 to 0.
- R4: A read is: an index write, a repeated START, then the address byte with bit 0 = 1. The slave sends the register at the current index MSB first and advances the index after each byte. It sends the next register after a host ACK. After a host NACK it releases the data line.
- R5: A START is SDA falling while SCL is high, and it is accepted in any state. A repeated START in the middle of a byte throws away the partial byte, writes nothing, and returns the slave to address reception.
- R6: A STOP is SDA rising while SCL is high. It ends the transaction. A data byte cut short by a STOP is not written.
- R7: bus_idle rises between T_BUF_CYC and T_BUF_CYC+5 cycles after both lines go high following a STOP or reset. In the middle of a transaction (after a START), it rises between T_HIGH_CYC and T_HIGH_CYC+5 cycles after both lines go high. It drops within 5 cycles of either line going low. Going idle abandons the transaction, so no later byte is ACKed until a new START.
- R8: While slave_en is low, the slave ignores the bus: it never pulls the data line low and changes no register.
- R9: After reset every register reads 0x00, sda_oe is 0 and bus_idle is 0.
- R10: While slave_en stays high, sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_en | input | 1 | Enables the bus interface |
| strap_addr | input | 4 | Added to BASE_ADDR to form the slave address |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 = pull the data line low |
| bus_idle | output | 1 | Bus idle after timeout |
| cfg_q | output | NREG*8 | Register contents; register i is in bits 8i+7:8i |

## Verification
A wrong state or bit count inside the byte engine shows up at the ports within the same byte. The ACK appears on the wrong clock or not at all, the read data comes out shifted, or a register in cfg_q changes that should not. A wrong index shows in the next cfg_q update or the next read byte. A mistake in the idle timer shows up as bus_idle rising outside its window, or as a missing ACK on the next byte after a long SCL-high interval.

// File: rtl/cbs_pkg.sv
// Shared types and helpers for the two-wire configuration slave.
// Assumes register data is always 8 bits wide.
package cbs_pkg;

    localparam int BYTE_W = 8;

    // Byte-engine states: receive/ack pairs for the write side, send/host-ack for reads.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WDATA,
        ST_ACK_DATA,
        ST_RDATA,
        ST_RACK
    } cbs_state_e;

endpackage

// File: rtl/cbs_line_sync.sv
// Brings SCL and SDA into the clk domain through a STAGES-deep synchronizer.
// Flags the bus events the byte engine needs: SCL edges, START and STOP.
// Assumes the bus is much slower than clk, so each level lasts many cycles.
// The flops reset to 1, the released-bus level.
module cbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift each raw line through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode edges; an SDA change while SCL is steady high is framing, not data.
    always_comb begin
        scl_rise = scl_s && !scl_d;
        scl_fall = !scl_s && scl_d;
        start_p  = scl_s && scl_d && sda_d && !sda_s;
        stop_p   = scl_s && scl_d && !sda_d && sda_s;
    end

endmodule

// File: rtl/cbs_idle_timer.sv
// Counts the cycles in which both bus lines are high and reports bus idle.
// After a STOP (and after reset) the short limit T_BUF_CYC applies.
// After a START the long limit T_HIGH_CYC applies.
// Assumes both limits are at least 1.
module cbs_idle_timer #(
    parameter int T_BUF_CYC  = 120,
    parameter int T_HIGH_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic start_p,
    input  logic stop_p,
    output logic bus_idle
);

    localparam int LIMIT_MAX = (T_BUF_CYC > T_HIGH_CYC) ? T_BUF_CYC : T_HIGH_CYC;
    localparam int CNT_W     = $clog2(LIMIT_MAX + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT_MAX);
    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(T_BUF_CYC);
    localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(T_HIGH_CYC);

    logic [CNT_W-1:0] high_cnt;
    logic             after_stop;
    logic             both_high;

    assign both_high = scl_s && sda_s;

    // Saturating count of consecutive both-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (!both_high) begin
            high_cnt <= '0;
        end else if (high_cnt != CNT_TOP) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    // Remember whether the last framing event was a STOP; reset counts as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_stop <= 1'b1;
        end else if (stop_p) begin
            after_stop <= 1'b1;
        end else if (start_p) begin
            after_stop <= 1'b0;
        end
    end

    // Compare the count with the limit that applies.
    always_comb begin
        bus_idle = both_high && (after_stop ? (high_cnt >= BUF_LIM) : (high_cnt >= HI_LIM));
    end

endmodule

// File: rtl/cbs_regbank.sv
// Bank of NREG configuration registers: one write port, one read port,
// and all contents brought out as one flat vector.
// Every register resets to zero.
module cbs_regbank #(
    parameter int NREG = 8,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [DW-1:0]           rd_data,
    output logic [NREG*DW-1:0]      flat_q
);

    localparam int IW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        // Hold or load one register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                regs[gi] <= wr_data;
            end
        end
        assign flat_q[gi*DW +: DW] = regs[gi];
    end

    // Read multiplexer for the byte currently indexed.
    always_comb begin
        rd_data = regs[rd_idx];
    end

endmodule

// File: rtl/cfg_bus_slave.sv
// Two-wire slave giving a host byte access to NREG configuration registers.
// Address = BASE_ADDR + strap_addr. Byte engine: write = index then data;
// read = data from the current index. The index auto-increments.
// Assumes NREG is a power of two and SCL is much slower than clk.
// The bus side is open drain: sda_oe = 1 pulls the data line low.
module cfg_bus_slave #(
    parameter logic [6:0] BASE_ADDR   = 7'h58,
    parameter int         NREG        = 8,
    parameter int         T_BUF_CYC   = 120,
    parameter int         T_HIGH_CYC  = 400,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slave_en,
    input  logic [3:0]          strap_addr,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_oe,
    output logic                bus_idle,
    output logic [NREG*8-1:0]   cfg_q
);

    import cbs_pkg::*;

    localparam int PW    = $clog2(NREG);
    localparam int CFG_W = NREG * BYTE_W;
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    cbs_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic              rw_bit;
    logic              host_ack;
    logic [PW-1:0]     ptr;
    logic              oe_q;
    logic [6:0]        my_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_done;

    cbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    cbs_idle_timer #(.T_BUF_CYC(T_BUF_CYC), .T_HIGH_CYC(T_HIGH_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .bus_idle (bus_idle)
    );

    // Strap-derived address; carries out of the low nibble are intended.
    assign my_addr   = BASE_ADDR + {3'b000, strap_addr};
    assign byte_done = scl_fall && (bitcnt == LAST_BIT);

    // A data byte is committed on the SCL fall that ends its eighth bit.
    assign wr_en = slave_en && !bus_idle && !start_p && !stop_p
                   && (state == ST_WDATA) && byte_done;

    cbs_regbank #(.NREG(NREG), .DW(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (rx_byte),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .flat_q  (cfg_q)
    );

    // Byte engine: bit counting, ACK generation, index handling, read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_byte  <= '0;
            tx_byte  <= '0;
            rw_bit   <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
            oe_q     <= 1'b0;
        end else if (!slave_en || bus_idle) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (start_p) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (stop_p) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && (bitcnt < LAST_BIT)) begin
                        rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
                        bitcnt  <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        if (state == ST_ADDR) begin
                            if (rx_byte[7:1] == my_addr) begin
                                rw_bit <= rx_byte[0];
                                oe_q   <= 1'b1;
                                state  <= ST_ACK_ADDR;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr   <= rx_byte[PW-1:0];
                            oe_q  <= 1'b1;
                            state <= ST_ACK_PTR;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            oe_q  <= 1'b1;
                            state <= ST_ACK_DATA;
                        end
                    end
                end
                ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_DATA: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if ((state == ST_ACK_ADDR) && rw_bit) begin
                            tx_byte <= rd_data;
                            oe_q    <= ~rd_data[7];
                            state   <= ST_RDATA;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= (state == ST_ACK_ADDR) ? ST_PTR : ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        oe_q  <= 1'b0;
                        ptr   <= ptr + 1'b1;
                        state <= ST_RACK;
                    end else if (scl_fall) begin
                        tx_byte <= {tx_byte[BYTE_W-2:0], 1'b0};
                        oe_q    <= ~tx_byte[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= !sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (host_ack) begin
                            tx_byte <= rd_data;
                            oe_q    <= ~rd_data[7];
                            state   <= ST_RDATA;
                        end else begin
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign sda_oe = oe_q;

endmodule

// File: rtl/cbs_checker.sv
// Properties for cfg_bus_slave, attached to it by the bind below.
module cbs_checker #(
    parameter int CFG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slave_en,
    input logic             scl_s,
    input logic             start_p,
    input logic             sda_oe,
    input logic             bus_idle,
    input logic [CFG_W-1:0] cfg_q
);

    // R8
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_en |=> !sda_oe);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slave_en) |-> $stable(cfg_q));

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && $past(slave_en) && !$stable(sda_oe)) |-> !$past(scl_s));

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_oe);

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (!sda_oe && !bus_idle));

endmodule

bind cfg_bus_slave cbs_checker #(.CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slave_en (slave_en),
    .scl_s    (scl_s),
    .start_p  (start_p),
    .sda_oe   (sda_oe),
    .bus_idle (bus_idle),
    .cfg_q    (cfg_q)
);

// File: tb/cfg_bus_slave_bench.sv
`timescale 1ns/1ps
module cfg_bus_slave_bench;

    localparam int NREG  = 8;
    localparam int TBUF  = 60;
    localparam int THIGH = 200;
    localparam int H     = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_en = 1'b1;
    logic [3:0] strap = 4'd0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, bus_idle;
    logic [NREG*8-1:0] cfg_q;
    wire  sda_line = ~(m_low | sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [4];

    always #2 clk = ~clk;

    cfg_bus_slave #(.NREG(NREG), .T_BUF_CYC(TBUF), .T_HIGH_CYC(THIGH)) u_cfg_bus_slave (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .strap_addr(strap),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe), .bus_idle(bus_idle),
        .cfg_q(cfg_q));

    function automatic logic [6:0] addr_of(input logic [3:0] s);
        return 7'h58 + {3'b000, s};
    endfunction

    function automatic logic [63:0] model_flat();
        logic [63:0] v = '0;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; cyc(H/2);
        scl_m = 1'b1; cyc(H);
        m_low = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(H/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; cyc(H/2);
        scl_m = 1'b1; cyc(H);
        m_low = 1'b0; cyc(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_low = ~b[i]; cyc(H/2);
            scl_m = 1'b1; cyc(H);
            scl_m = 1'b0; cyc(H/2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 1'b0; cyc(H/2);
        scl_m = 1'b1; cyc(H/2);
        ack = ~sda_line; cyc(H/2);
        scl_m = 1'b0; cyc(H/2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            cyc(H/2); scl_m = 1'b1;
            cyc(H/2); b[i] = sda_line;
            cyc(H/2); scl_m = 1'b0;
            cyc(H/2);
        end
        m_low = give_ack; cyc(H/2);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(H/2);
        m_low = 1'b0;
    endtask

    // Full write transaction; checks every ACK and updates the model.
    task automatic do_write(input logic [6:0] a7, input logic [7:0] pb, input int n,
                            input bit exp_ack, input string req);
        bit ack;
        bus_start();
        send_byte({a7, 1'b0}, ack);
        chk(ack == exp_ack, {req, " address ack"}, ack, exp_ack);
        send_byte(pb, ack);
        chk(ack == exp_ack, {req, " index ack"}, ack, exp_ack);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack == exp_ack, {req, " data ack"}, ack, exp_ack);
            if (exp_ack) model[(pb + i) % NREG] = wbuf[i];
        end
        bus_stop();
        chk(cfg_q == model_flat(), {req, " register contents"}, cfg_q, model_flat());
    endtask

    // Index write, repeated START, read n bytes with NACK on the last one.
    task automatic do_read(input logic [7:0] pb, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({addr_of(strap), 1'b0}, ack);
        chk(ack, "R4 address ack", ack, 1);
        send_byte(pb, ack);
        chk(ack, "R4 index ack", ack, 1);
        bus_start();
        send_byte({addr_of(strap), 1'b1}, ack);
        chk(ack, "R4 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == model[(pb + i) % NREG], "R4 read data", b, model[(pb + i) % NREG]);
        end
        cyc(4);
        chk(sda_oe == 1'b0, "R4 release after NACK", sda_oe, 0);
        bus_stop();
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        bit ack;
        logic [6:0] a7;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        cyc(5);
        // R9: reset state
        chk(sda_oe == 1'b0, "R9 sda_oe in reset", sda_oe, 0);
        chk(bus_idle == 1'b0, "R9 bus_idle in reset", bus_idle, 0);
        chk(cfg_q == '0, "R9 registers in reset", cfg_q, 0);
        rst_n = 1'b1;
        n = 0;
        while (!bus_idle && n < 1000) begin cyc(1); n++; end
        chk(n >= TBUF && n <= TBUF + 5, "R7 idle after reset", n, TBUF);

        // R1: strap 0 -> 0xB0
        strap = 4'd0; wbuf[0] = 8'hA5;
        do_write(7'h58, 8'h00, 1, 1'b1, "R1 strap0");
        // R1 + R3: strap 15 -> 0xCE, index wrap 7 -> 0
        strap = 4'd15; wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(7'h67, 8'h07, 2, 1'b1, "R1 R3 strap15 wrap");
        // R3: only the low 3 bits of the index byte are used (0x0B -> 3)
        wbuf[0] = 8'h3C;
        do_write(7'h67, 8'h0B, 1, 1'b1, "R3 index low bits");

        // Random writes, matching and not matching (R2, R3)
        for (int t = 0; t < 18; t++) begin
            bit hit;
            strap = 4'($urandom % 16);
            hit = ($urandom % 4) != 0;
            a7 = hit ? addr_of(strap) : addr_of(strap) + 7'(1 + $urandom % 100);
            for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
            do_write(a7, 8'($urandom), 1 + $urandom % 4, hit, hit ? "R3 random write" : "R2 foreign address");
        end

        // Random reads (R4)
        for (int t = 0; t < 10; t++) begin
            strap = 4'($urandom % 16);
            do_read(8'($urandom), 1 + $urandom % 4);
        end

        // R5: repeated START in the middle of a data byte
        strap = 4'd3;
        bus_start();
        send_byte({addr_of(strap), 1'b0}, ack);
        send_byte(8'h02, ack);
        send_bits(8'hE7, 5);
        wbuf[0] = 8'h5A;
        do_write(addr_of(strap), 8'h04, 1, 1'b1, "R5 repeated start mid byte");

        // R6: STOP in the middle of a data byte
        bus_start();
        send_byte({addr_of(strap), 1'b0}, ack);
        send_byte(8'h05, ack);
        send_bits(8'h00, 3);
        bus_stop();
        chk(cfg_q == model_flat(), "R6 partial byte not written", cfg_q, model_flat());
        // R7: time to idle after this STOP
        n = 0;
        while (!bus_idle && n < 1000) begin cyc(1); n++; end
        chk(n >= TBUF - H && n <= TBUF + 5 - H, "R7 idle after stop", n, TBUF - H);

        // R8: interface disabled
        slave_en = 1'b0;
        wbuf[0] = 8'hFF;
        do_write(addr_of(strap), 8'h01, 1, 1'b0, "R8 disabled");
        slave_en = 1'b1;

        // R7: long SCL-high during a transaction abandons it
        bus_start();
        send_byte({addr_of(strap), 1'b0}, ack);
        chk(ack, "R7 address ack before timeout", ack, 1);
        send_byte(8'h06, ack);
        m_low = 1'b0; cyc(H/2);
        scl_m = 1'b1;
        n = 0;
        while (!bus_idle && n < 1000) begin cyc(1); n++; end
        chk(n >= THIGH && n <= THIGH + 5, "R7 idle in transaction", n, THIGH);
        scl_m = 1'b0; cyc(5);
        chk(bus_idle == 1'b0, "R7 idle drops", bus_idle, 0);
        cyc(H/2 - 5);
        send_byte(8'hC3, ack);
        chk(ack == 1'b0, "R7 no ack after idle", ack, 0);
        bus_stop();
        chk(cfg_q == model_flat(), "R7 register kept after idle", cfg_q, model_flat());

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule